// File: doc/BRIEF.md
# ADC Conversion Start Trigger Selector

This block issues the one-clock pulse that starts an analog-to-digital conversion. A two-bit mode input picks the source of that pulse. The source is a timer overflow strobe, a software start strobe, or an edge on an external pin. The pin is asynchronous, and a polarity bit chooses whether its rising or its falling edge counts. The pin goes through a synchronizer and an edge detector inside the block.

While the conversion sequencer reports busy, the block discards every trigger, whatever its source. Dropped triggers are not stored, so none of them causes a late start once busy clears. The selector does not depend on the sequencer mode, so it can sit in front of any conversion ordering.

Top module: `adc_start_sel`

## Requirements
- R1: With mode_i = 0 (timer), a high tmr_ovf_i sampled at a clock edge while busy_i and start_o are low makes start_o high for the following cycle.
- R2: With mode_i = 1 (software), a high sw_start_i sampled at a clock edge while busy_i and start_o are low makes start_o high for the following cycle.
- R3: With mode_i = 2 (pin), an edge on pin_i of the selected polarity (fall_i = 0 selects rising, fall_i = 1 selects falling) makes start_o high for exactly one cycle. If pin_i changes just before clock edge k, start_o is high in the cycle after edge k+2. An edge of the other polarity produces no pulse.
- R4: Any trigger that arrives while busy_i is high is dropped. start_o stays low in the next cycle, and the trigger causes no pulse after busy_i falls.
- R5: start_o is never high in two consecutive cycles. A trigger sampled while start_o is high is dropped.
- R6: Only the source chosen by mode_i can start a conversion. mode_i = 3 starts nothing.
- R7: If the pin level is held steady, changing mode_i or fall_i produces no start pulse.
- R8: During reset start_o is low. The pin level present when reset is released is not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Source select: 0 timer, 1 software, 2 pin edge, 3 none |
| fall_i | input | 1 | Pin edge polarity: 0 rising, 1 falling |
| sw_start_i | input | 1 | Software start strobe |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| pin_i | input | 1 | Asynchronous external trigger pin |
| busy_i | input | 1 | Conversion in progress, from the sequencer |
| start_o | output | 1 | One-cycle conversion start pulse |

## Verification
A corrupted lockout shows one cycle after the trigger. It appears either as a start_o pulse in a cycle that follows busy_i, or as two back-to-back pulses. A stale previous-level or arm flag in the pin path shows within three cycles of a pin change, a mode change or reset release, as a missing pulse, a doubled pulse or a spurious pulse. A wrong mode decode shows on the first strobe from a source that is not selected.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_SOFT  = 2'd1,
    SRC_PIN   = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic vld_o
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] vld;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          q[0]   <= 1'b0;
          vld[0] <= 1'b0;
        end else begin
          q[0]   <= d_i;
          vld[0] <= 1'b1;
        end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          q[i]   <= 1'b0;
          vld[i] <= 1'b0;
        end else begin
          q[i]   <= q[i-1];
          vld[i] <= vld[i-1];
        end
    end
  end

  assign q_o   = q[STAGES-1];
  assign vld_o = vld[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic vld_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q, arm_q;

  // prev tracks the pin in every mode, so a mode switch cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      arm_q  <= vld_i;
    end

  assign rise_o = arm_q &  lvl_i & ~prev_q;
  assign fall_o = arm_q & ~lvl_i &  prev_q;
endmodule

// File: rtl/trig_gate.sv
module trig_gate
  import adc_start_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic fall_sel_i,
  input  logic sw_i,
  input  logic tmr_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic busy_i,
  output logic start_o
);
  logic hit, start_q;

  always_comb begin
    unique case (src_i)
      SRC_TIMER: hit = tmr_i;
      SRC_SOFT:  hit = sw_i;
      SRC_PIN:   hit = fall_sel_i ? fall_i : rise_i;
      default:   hit = 1'b0;
    endcase
  end

  // drop, never queue: busy or a pulse in flight kills the trigger
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= hit & ~busy_i & ~start_q;

  assign start_o = start_q;
endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_start_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       fall_i,
  input  logic       sw_start_i,
  input  logic       tmr_ovf_i,
  input  logic       pin_i,
  input  logic       busy_i,
  output logic       start_o
);
  logic pin_s, pin_vld, pin_rise, pin_fall;

  pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s),
    .vld_o (pin_vld)
  );

  edge_det i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_s),
    .vld_i (pin_vld),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  trig_gate i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_e'(mode_i)),
    .fall_sel_i(fall_i),
    .sw_i      (sw_start_i),
    .tmr_i     (tmr_ovf_i),
    .rise_i    (pin_rise),
    .fall_i    (pin_fall),
    .busy_i    (busy_i),
    .start_o   (start_o)
  );
endmodule

// File: rtl/adc_start_sel_chk.sv
module adc_start_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       sw_start_i,
  input logic       tmr_ovf_i,
  input logic       busy_i,
  input logic       start_o
);
  a_r1_timer_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && tmr_ovf_i && !busy_i && !start_o) |=> start_o);

  a_r2_soft_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && sw_start_i && !busy_i && !start_o) |=> start_o);

  a_r4_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !start_o);

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r6_none_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> !start_o);

  a_r6_timer_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !tmr_ovf_i) |=> !start_o);

  a_r6_soft_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !sw_start_i) |=> !start_o);

  always_comb
    if (!rst_ni) a_r8_reset_low: assert (!start_o);
endmodule

bind adc_start_sel adc_start_sel_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .sw_start_i(sw_start_i),
  .tmr_ovf_i (tmr_ovf_i),
  .busy_i    (busy_i),
  .start_o   (start_o)
);

// File: tb/test_adc_start_sel.sv
module test_adc_start_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic fall = 1'b0, sw = 1'b0, tmr = 1'b0, pin = 1'b1, busy = 1'b0;
  logic start;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_start_sel i_adc_start_sel (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fall_i(fall),
    .sw_start_i(sw), .tmr_ovf_i(tmr), .pin_i(pin), .busy_i(busy),
    .start_o(start)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic sw;
    logic tmr;
    logic busy;
    logic exp;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1},  // R1 timer start
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 trigger during pulse
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 timer while busy
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 not remembered
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 soft in timer mode
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 soft start
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 timer in soft mode
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 mode 3
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 soft while busy
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 not remembered
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1}   // R2 again
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count pulses over n negedges; first = index (1-based) of first pulse
  task automatic watch(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (start) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt, first;
    // R8 reset with pin high in pin/rising mode
    repeat (3) @(negedge clk);
    check("R8 reset low", int'(start), 0);
    rst_n = 1'b1;
    watch(8, cnt, first);
    check("R8 no edge at reset release", cnt, 0);

    foreach (VEC[i]) begin
      mode = VEC[i].mode; sw = VEC[i].sw; tmr = VEC[i].tmr; busy = VEC[i].busy;
      @(negedge clk);
      check($sformatf("R1/R2/R4/R5/R6 vector %0d", i), int'(start), int'(VEC[i].exp));
    end
    sw = 1'b0; tmr = 1'b0; busy = 1'b0;

    // R7 mode switch with pin held high
    mode = 2'd2; fall = 1'b0;
    watch(6, cnt, first);
    check("R7 mode switch no pulse", cnt, 0);

    // R3 falling edge with rising selected
    pin = 1'b0;
    watch(6, cnt, first);
    check("R3 wrong polarity ignored", cnt, 0);

    // R3 rising edge
    pin = 1'b1;
    watch(6, cnt, first);
    check("R3 rising pulse count", cnt, 1);
    check("R3 rising pulse latency", first, 3);

    // R7 polarity change with pin held high
    fall = 1'b1;
    watch(6, cnt, first);
    check("R7 polarity change no pulse", cnt, 0);

    // R3 falling edge selected
    pin = 1'b0;
    watch(6, cnt, first);
    check("R3 falling pulse count", cnt, 1);
    check("R3 falling pulse latency", first, 3);

    // R4 pin edge while busy, not remembered
    fall = 1'b0; busy = 1'b1;
    pin = 1'b1;
    watch(6, cnt, first);
    busy = 1'b0;
    watch(6, cnt, first);
    check("R4 pin edge during busy dropped", cnt, 0);

    // R6 pin edge in timer mode
    mode = 2'd0; pin = 1'b0;
    watch(4, cnt, first);
    pin = 1'b1;
    watch(6, cnt, first);
    check("R6 pin ignored in timer mode", cnt, 0);

    // R5 soft strobe held high: pulses never adjacent
    mode = 2'd1; sw = 1'b1;
    watch(4, cnt, first);
    sw = 1'b0;
    check("R5 held strobe alternates", cnt, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule